// File: doc/BRIEF.md
# Accumulator Teaching Processor

This block is a very small multicycle processor built around one accumulator. A single memory of sixteen 8-bit words holds both the program and its data. Each word read as an instruction carries an operation code in its upper four bits and a memory address in its lower four bits. A program counter and a memory address register select words. The instruction register, the accumulator, a second operand register and an output register are the only other state. The only arithmetic is an 8-bit adder that sums the accumulator and the operand register.

A host holds the processor in reset and writes the program and data through a load port, one word per clock. When reset is released, execution starts at address 0. Every instruction takes six clocks, paced by a one-hot ring of timing states. The first three states fetch the instruction: the address is taken from the program counter, the counter is incremented, and the word is read into the instruction register. The last three states execute it. A halt instruction freezes the processor until the next reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high, `result` reads 0 and `halted` reads 0. After reset is released, execution starts at address 0.
- R2: Opcode 4'b0000 (load) copies the memory word at the operand address into the accumulator.
- R3: Opcode 4'b0001 (add) reads the operand word into the operand register and then replaces the accumulator with the sum. The sum wraps modulo 256.
- R4: Opcode 4'b0010 (subtract) reads the operand word and then replaces the accumulator with the accumulator minus that word, modulo 256 in two's complement.
- R5: Opcode 4'b1110 (output) copies the accumulator to `result`. `result` holds that value until the next output instruction.
- R6: Opcode 4'b1111 (halt) raises `halted`. From then on, `halted` and `result` stay constant until reset.
- R7: Every instruction takes exactly six clocks. The instruction at position i (counting from 0 after reset) reaches its fourth timing state on clock edge 6i+4 after reset is released, where edge 1 is the first edge with reset low. An output instruction updates `result` on that edge, and a halt instruction raises `halted` on that edge.
- R8: Any other opcode leaves the accumulator unchanged and takes the same six clocks.
- R9: The load port writes memory only while reset is high. Writes made while running are ignored, and memory contents survive a reset.
- R10: The program counter wraps from 15 to 0, so execution goes on at address 0 after address 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; the load port is live only while it is high |
| ld_we | input | 1 | Load port write strobe |
| ld_addr | input | 4 | Load port word address |
| ld_data | input | 8 | Load port write data |
| result | output | 8 | Output register |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench aims at the carry out of bit 7 (200+100). A design that kept the carry, or saturated, would show a value other than 0x2C. It also tests a subtraction with a negative result, which a design that forgot the +1 would get wrong by one. It checks `result` and `halted` on the exact edges that the six-state timing predicts, so a ring with a missing or extra state shows a value one instruction too early or too late. Further tests cover undefined opcodes acting as data, a write on the load port during execution, and program counter wrap-around. A design that corrupted the accumulator, accepted the late write, or jumped anywhere other than address 0 after address 15 would output a wrong value.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] result,
  output logic          halted
);
  localparam int DEPTH = 1 << AW;
  localparam int OPW   = DW - AW;
  localparam logic [OPW-1:0] OP_LOAD = OPW'(4'h0);
  localparam logic [OPW-1:0] OP_ADD  = OPW'(4'h1);
  localparam logic [OPW-1:0] OP_SUB  = OPW'(4'h2);
  localparam logic [OPW-1:0] OP_SHOW = OPW'(4'hE);
  localparam logic [OPW-1:0] OP_STOP = OPW'(4'hF);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] ir, acc, opnd;
  logic [5:0]    t;

  wire [OPW-1:0] op      = ir[DW-1:AW];
  wire [DW-1:0]  rd      = mem[mar];
  wire           uses_m  = (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB);

  always_ff @(posedge clk)
    if (rst && ld_we) mem[ld_addr] <= ld_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0; mar <= '0; ir <= '0; acc <= '0; opnd <= '0;
      result <= '0; halted <= 1'b0; t <= 6'b000001;
    end else if (!halted) begin
      t <= {t[4:0], t[5]};
      if (t[0]) mar <= pc;
      if (t[1]) pc <= pc + 1'b1;
      if (t[2]) ir <= rd;
      if (t[3]) begin
        if (uses_m)          mar <= ir[AW-1:0];
        if (op == OP_SHOW)   result <= acc;
        if (op == OP_STOP)   halted <= 1'b1;
      end
      if (t[4]) begin
        if (op == OP_LOAD)                   acc <= rd;
        if (op == OP_ADD || op == OP_SUB)    opnd <= rd;
      end
      if (t[5]) begin
        if (op == OP_ADD) acc <= acc + opnd;
        if (op == OP_SUB) acc <= acc + ~opnd + 1'b1;
      end
    end
  end

  // R7
  ring_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(t) == 1);

  // R6
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(result) && $stable(acc));

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(t[3] && op == OP_SHOW && !halted) |=> $stable(result));

  // R3
  add_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (t[5] && op == OP_ADD && !halted) |=> acc == DW'($past(acc) + $past(opnd)));

  // R4
  sub_chk: assert property (@(posedge clk) disable iff (rst)
    (t[5] && op == OP_SUB && !halted) |=> acc == DW'($past(acc) - $past(opnd)));

  // R9
  load_lock_chk: assert property (@(posedge clk) disable iff (rst)
    ld_we |=> mem[$past(ld_addr)] == $past(mem[ld_addr]));
endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_we = 1'b0;
  logic [3:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [7:0] result;
  logic halted;
  int errors = 0;
  int checks = 0;
  int ecount = 0;
  logic [7:0] img [16];

  acc_cpu dut (.clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr),
               .ld_data(ld_data), .result(result), .halted(halted));

  always #4 clk = ~clk;

  always @(posedge clk) ecount <= rst ? 0 : ecount + 1;

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish (actual=timeout expected=done)");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 16; i++) img[i] = 8'h40;
  endtask

  task automatic load_and_go(input bit do_load);
    @(negedge clk);
    rst = 1'b1;
    if (do_load)
      for (int i = 0; i < 16; i++) begin
        ld_we = 1'b1; ld_addr = 4'(i); ld_data = img[i];
        @(negedge clk);
      end
    else
      @(negedge clk);
    ld_we = 1'b0;
    rst = 1'b0;
  endtask

  task automatic at_edge(input int e);
    @(negedge clk);
    while (ecount < e) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 result in reset", result, 8'h00);
    chk("R1 halted in reset", {7'b0, halted}, 8'h00);
  endtask

  task automatic t_add_wrap();
    clear_img();
    img[0] = 8'h0E; img[1] = 8'h1F; img[2] = 8'hE0; img[3] = 8'hF0;
    img[14] = 8'd200; img[15] = 8'd100;
    load_and_go(1'b1);
    at_edge(15);
    chk("R7 result before output edge", result, 8'h00);
    at_edge(16);
    chk("R3 R2 wrapped sum", result, 8'h2C);
    at_edge(21);
    chk("R7 not halted before edge 22", {7'b0, halted}, 8'h00);
    at_edge(22);
    chk("R6 halted on edge 22", {7'b0, halted}, 8'h01);
    at_edge(80);
    chk("R6 result frozen", result, 8'h2C);
    chk("R6 stays halted", {7'b0, halted}, 8'h01);
  endtask

  task automatic t_sub();
    clear_img();
    img[0] = 8'h0D; img[1] = 8'h2E; img[2] = 8'hE0; img[3] = 8'h0F;
    img[4] = 8'hE0; img[5] = 8'hF0;
    img[13] = 8'h05; img[14] = 8'h09; img[15] = 8'h33;
    load_and_go(1'b1);
    chk("R1 result after restart", result, 8'h00);
    at_edge(16);
    chk("R4 negative difference", result, 8'hFC);
    at_edge(27);
    chk("R5 result held", result, 8'hFC);
    at_edge(28);
    chk("R5 second output", result, 8'h33);
    at_edge(34);
    chk("R6 halt at edge 34", {7'b0, halted}, 8'h01);
  endtask

  task automatic t_undef_and_lock();
    clear_img();
    img[0] = 8'h0E; img[1] = 8'h5E; img[2] = 8'h3F; img[3] = 8'hE0; img[4] = 8'hF0;
    img[14] = 8'h11; img[15] = 8'h77;
    load_and_go(1'b1);
    at_edge(2);
    ld_we = 1'b1; ld_addr = 4'hE; ld_data = 8'h99;
    @(negedge clk);
    ld_we = 1'b0;
    at_edge(22);
    chk("R8 undefined opcodes keep acc", result, 8'h11);
    chk("R9 running write ignored", result, 8'h11);
    at_edge(28);
    chk("R6 halt after nops", {7'b0, halted}, 8'h01);
    load_and_go(1'b0);
    at_edge(22);
    chk("R9 memory survives reset", result, 8'h11);
  endtask

  task automatic t_wrap();
    clear_img();
    img[0] = 8'hE0; img[1] = 8'h02; img[2] = 8'h42;
    load_and_go(1'b1);
    at_edge(4);
    chk("R1 first output from address 0", result, 8'h00);
    at_edge(99);
    chk("R10 before wrap", result, 8'h00);
    at_edge(100);
    chk("R10 pc wrapped to 0", result, 8'h42);
    chk("R10 not halted", {7'b0, halted}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_add_wrap();
    t_sub();
    t_undef_and_lock();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule